// File: doc/BRIEF.md
# If-Then Predication State Tracker

This block keeps the predication state that a 16-bit if-then prefix sets up in a compact instruction stream. The prefix names a base condition and a pattern of up to three further slots, each either "then" (same condition) or "else" (inverted condition). For each instruction that follows, the tracker shows which condition applies to it. It tests that condition against the current N, Z, C and V flags and reports whether the instruction executes or is skipped. The state moves forward by one slot each time an instruction retires.

The state is a single packed 8-bit word. The upper nibble holds the condition for the current slot. The lower nibble is a shift mask, and its lowest set bit marks the last slot. An exception handler can read the word and write it back, so that execution resumes at any position inside a block. The tracker also flags four illegal patterns: a prefix nested inside an active block, an always-condition prefix that asks for an else slot, a branch that lands inside an active block, and a write to the flag register from inside an active block.

Top module: `pred_track`

## Requirements
- R1: After a synchronous reset, `st_q` is 0x00, `blk_active` is 0, `slot_cond` is 0xE, `slot_pass` is 1 and `err` is 0.
- R2: A valid word with bits [15:8] = 0xBF and a non-zero low nibble is a prefix. When no block is active, a legal prefix loads `st_q` = {word[7:4], word[3:0]} on the next clock edge. A 0xBF word whose low nibble is zero is not a prefix and leaves the state unchanged.
- R3: The first slot of a block uses the base condition: `slot_cond` equals word[7:4] of the prefix.
- R4: When a slot retires and a later slot remains, bits [4:0] of the state shift left by one and bits [7:5] keep their value. `slot_cond` is always `st_q[7:4]`. A then slot therefore repeats the base condition, and an else slot gets the base with bit 0 flipped.
- R5: A block lasts 1, 2, 3 or 4 slots when the lowest set mask bit is bit 3, 2, 1 or 0. When the last slot retires, `st_q` returns to 0x00.
- R6: Prefix word 0xBF14 gives a two-slot block: the first slot has condition NE (0x1), the second has EQ (0x0), and after that the block is idle.
- R7: `slot_pass` evaluates `slot_cond` against `nzcv` = {N,Z,C,V} with the codes 0 EQ Z, 1 NE !Z, 2 CS C, 3 CC !C, 4 MI N, 5 PL !N, 6 VS V, 7 VC !V, 8 HI C&!Z, 9 LS !(C&!Z), A GE N==V, B LT N!=V, C GT !Z&(N==V), D LE its inverse, E and F always true.
- R8: When no block is active, `slot_cond` is 0xE and `slot_pass` is 1, and a valid instruction that is not a prefix leaves `st_q` at 0x00.
- R9: `st_wr` loads `st_q` from `st_wdata` on the next edge. It takes priority over a retire or prefix in the same cycle.
- R10: `err[0]` is high in a cycle where a valid prefix is seen while a block is active. That prefix retires as an ordinary slot.
- R11: `err[1]` is high in a cycle where, with no block active, a prefix with base 0xE has more than one set mask bit (an else slot). Such a prefix loads nothing.
- R12: `err[2]` is high in a cycle where a valid instruction with `ins_is_tgt` set arrives while a block is active. It is low when no block is active.
- R13: `err[3]` is high in a cycle where a valid instruction with `ins_wr_flags` set arrives while a block is active. It is low when no block is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction retires this cycle |
| ins_word | input | 16 | Leading 16-bit encoding of that instruction |
| ins_is_tgt | input | 1 | The instruction is the target of a taken branch |
| ins_wr_flags | input | 1 | The instruction writes the flag/status register |
| nzcv | input | 4 | Current flags {N,Z,C,V} |
| st_wr | input | 1 | Restore strobe for the state word |
| st_wdata | input | 8 | Saved state word to restore |
| st_q | output | 8 | Current state word {condition, mask} |
| blk_active | output | 1 | A block is in progress |
| slot_cond | output | 4 | Condition that applies to the current instruction |
| slot_pass | output | 1 | The current instruction executes (1) or is skipped (0) |
| err | output | 4 | Violations: [0] nested prefix, [1] always-with-else, [2] branch into block, [3] flag write in block |

## Verification
A restore write and an instruction retire can fall in the same cycle. The bench provokes this inside an active block by asserting `st_wr` with a new word while a valid instruction retires. It judges the outcome by reading `st_q` on the next cycle, which must hold the restored word and not the shifted one. A second overlap occurs when a prefix arrives while a block is active. In that cycle the nested-prefix error must rise and the state must advance as for an ordinary slot, not reload from the new prefix.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int INS_W   = 16;
    localparam int COND_W  = 4;
    localparam int MASK_W  = 4;
    localparam int ST_W    = COND_W + MASK_W;
    localparam int ERR_W   = 4;
    localparam int PAIRS   = 1 << (COND_W - 1);
    localparam logic [INS_W-COND_W-MASK_W-1:0] PFX_OP = 8'hBF;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cc_e;

    typedef enum int {
        ERR_NEST   = 0,
        ERR_ALELSE = 1,
        ERR_BRIN   = 2,
        ERR_FLGWR  = 3
    } err_idx_e;

    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic [MASK_W-1:0] mask;
    } pstate_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic              is_pfx;
        logic              al_else;
        logic [COND_W-1:0] base;
        logic [MASK_W-1:0] mask;
    } pfx_t;

    function automatic logic st_busy(input pstate_t s);
        return s.mask != '0;
    endfunction

    // True when the slot now retiring is the last one of the block.
    function automatic logic st_last(input pstate_t s);
        return s.mask[MASK_W-2:0] == '0;
    endfunction

    // Moves on to the next slot: the low condition bit and the mask
    // shift together, so the next mask bit becomes the condition LSB.
    function automatic pstate_t st_step(input pstate_t s);
        pstate_t r;
        r = s;
        if (st_last(s)) begin
            r = '0;
        end else begin
            r[MASK_W:0] = {s[MASK_W-1:0], 1'b0};
        end
        return r;
    endfunction

    // Truth of the even (non-inverted) member of each condition pair.
    function automatic logic pair_true(input int unsigned p, input flags_t f);
        logic r;
        case (p)
            0: r = f.z;
            1: r = f.c;
            2: r = f.n;
            3: r = f.v;
            4: r = f.c & ~f.z;
            5: r = (f.n == f.v);
            6: r = ~f.z & (f.n == f.v);
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pred_pfx_dec.sv
module pred_pfx_dec
    import pred_pkg::*;
(
    input  logic [INS_W-1:0] word,
    output pfx_t             pfx
);
    localparam int OP_LSB = COND_W + MASK_W;

    logic [MASK_W-1:0] m;
    logic [COND_W-1:0] b;
    logic              multi;

    assign m = word[MASK_W-1:0];
    assign b = word[OP_LSB-1:MASK_W];
    // More than one set bit means a slot beyond the first carries
    // the inverse of the (zero) condition LSB, which is an else slot.
    assign multi = (m & (m - 1'b1)) != '0;

    always_comb begin
        pfx.is_pfx  = (word[INS_W-1:OP_LSB] == PFX_OP) && (m != '0);
        pfx.base    = b;
        pfx.mask    = m;
        pfx.al_else = (b == CC_AL) && multi;
    end
endmodule

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
    import pred_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  flags_t            flags,
    output logic              pass
);
    logic [PAIRS-1:0] even_ok;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign even_ok[p] = pair_true(p, flags);
    end

    logic [COND_W-2:0] sel;
    logic              inv;

    assign sel  = cond[COND_W-1:1];
    // The last pair has no inverted form: both codes are always true.
    assign inv  = cond[0] & (sel != {(COND_W-1){1'b1}});
    assign pass = even_ok[sel] ^ inv;
endmodule

// File: rtl/pred_state_reg.sv
module pred_state_reg
    import pred_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restore,
    input  pstate_t restore_val,
    input  logic    retire,
    input  logic    load,
    input  pstate_t load_val,
    output pstate_t q
);
    pstate_t nxt;

    always_comb begin
        nxt = q;
        if (restore) begin
            nxt = restore_val;
        end else if (retire && st_busy(q)) begin
            nxt = st_step(q);
        end else if (load) begin
            nxt = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/pred_track.sv
module pred_track
    import pred_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [INS_W-1:0]  ins_word,
    input  logic              ins_is_tgt,
    input  logic              ins_wr_flags,
    input  logic [3:0]        nzcv,
    input  logic              st_wr,
    input  logic [ST_W-1:0]   st_wdata,
    output logic [ST_W-1:0]   st_q,
    output logic              blk_active,
    output logic [COND_W-1:0] slot_cond,
    output logic              slot_pass,
    output logic [ERR_W-1:0]  err
);
    pfx_t    pfx;
    pstate_t cur;
    pstate_t ld_val;
    logic    busy;
    logic    raw_pass;
    logic    ld_ok;

    pred_pfx_dec u_dec (
        .word (ins_word),
        .pfx  (pfx)
    );

    assign busy   = st_busy(cur);
    assign ld_ok  = ins_valid && !busy && pfx.is_pfx && !pfx.al_else;
    assign ld_val = '{cond: pfx.base, mask: pfx.mask};

    pred_state_reg u_st (
        .clk         (clk),
        .rst         (rst),
        .restore     (st_wr),
        .restore_val (pstate_t'(st_wdata)),
        .retire      (ins_valid),
        .load        (ld_ok),
        .load_val    (ld_val),
        .q           (cur)
    );

    pred_cond_eval u_ev (
        .cond  (cur.cond),
        .flags (flags_t'(nzcv)),
        .pass  (raw_pass)
    );

    always_comb begin
        err                 = '0;
        err[ERR_NEST]       = ins_valid && busy && pfx.is_pfx;
        err[ERR_ALELSE]     = ins_valid && !busy && pfx.is_pfx && pfx.al_else;
        err[ERR_BRIN]       = ins_valid && busy && ins_is_tgt;
        err[ERR_FLGWR]      = ins_valid && busy && ins_wr_flags;
    end

    assign st_q       = cur;
    assign blk_active = busy;
    assign slot_cond  = busy ? cur.cond : CC_AL;
    assign slot_pass  = busy ? raw_pass : 1'b1;
endmodule

// File: rtl/pred_track_chk.sv
module pred_track_chk
    import pred_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ins_valid,
    input logic [INS_W-1:0]  ins_word,
    input logic              ins_is_tgt,
    input logic              ins_wr_flags,
    input logic [3:0]        nzcv,
    input logic              st_wr,
    input logic [ST_W-1:0]   st_wdata,
    input logic [ST_W-1:0]   st_q,
    input logic              blk_active,
    input logic [COND_W-1:0] slot_cond,
    input logic              slot_pass,
    input logic [ERR_W-1:0]  err
);
    logic pfx_seen;
    assign pfx_seen = (ins_word[15:8] == 8'hBF) && (ins_word[3:0] != 4'h0);

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> st_q == 8'h00);

    // R9
    restore_wins_chk: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> st_q == $past(st_wdata));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !st_wr && !blk_active && !pfx_seen) |=> st_q == 8'h00);

    // R8
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !blk_active |-> (slot_cond == 4'hE) && slot_pass);

    // R4
    base_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !st_wr && blk_active && st_q[2:0] != 3'b000)
        |=> st_q[7:5] == $past(st_q[7:5]));

    // R5
    last_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !st_wr && blk_active && st_q[2:0] == 3'b000) |=> st_q == 8'h00);

    // R10
    nest_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && blk_active && pfx_seen) |-> err[0]);

    // R12
    brin_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && blk_active && ins_is_tgt) |-> err[2]);

    // R13
    flgwr_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && blk_active && ins_wr_flags) |-> err[3]);

    // R12
    idle_err_chk: assert property (@(posedge clk) disable iff (rst)
        !blk_active |-> (err[0] == 1'b0) && (err[2] == 1'b0) && (err[3] == 1'b0));

    // R7
    eq_eval_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_active && slot_cond == 4'h0) |-> slot_pass == nzcv[2]);
endmodule

bind pred_track pred_track_chk u_chk (.*);

// File: tb/pred_track_tb.sv
module pred_track_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ins_valid, ins_is_tgt, ins_wr_flags, st_wr;
    logic [15:0] ins_word;
    logic [3:0]  nzcv;
    logic [7:0]  st_wdata;
    logic [7:0]  st_q;
    logic        blk_active;
    logic [3:0]  slot_cond;
    logic        slot_pass;
    logic [3:0]  err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    pred_track u_dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word),
        .ins_is_tgt(ins_is_tgt), .ins_wr_flags(ins_wr_flags), .nzcv(nzcv),
        .st_wr(st_wr), .st_wdata(st_wdata), .st_q(st_q), .blk_active(blk_active),
        .slot_cond(slot_cond), .slot_pass(slot_pass), .err(err)
    );

    // {base condition, nzcv, expected pass}
    localparam logic [8:0] VEC [0:17] = '{
        {4'h0, 4'b0100, 1'b1}, {4'h0, 4'b0000, 1'b0},
        {4'h1, 4'b0000, 1'b1}, {4'h2, 4'b0010, 1'b1},
        {4'h3, 4'b0010, 1'b0}, {4'h4, 4'b1000, 1'b1},
        {4'h5, 4'b1000, 1'b0}, {4'h6, 4'b0001, 1'b1},
        {4'h7, 4'b0000, 1'b1}, {4'h8, 4'b0010, 1'b1},
        {4'h8, 4'b0110, 1'b0}, {4'h9, 4'b0110, 1'b1},
        {4'hA, 4'b1001, 1'b1}, {4'hB, 4'b1000, 1'b1},
        {4'hC, 4'b0000, 1'b1}, {4'hC, 4'b1100, 1'b0},
        {4'hD, 4'b0100, 1'b1}, {4'hE, 4'b0000, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic [15:0] w, input logic t, input logic f);
        ins_valid = v; ins_word = w; ins_is_tgt = t; ins_wr_flags = f;
        #1;
    endtask

    task automatic adv;
        @(negedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; st_wr = 1'b0; st_wdata = '0; nzcv = '0;
        put(0, 16'h0000, 0, 0);
        repeat (2) adv();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 st_q", st_q, 8'h00);
        chk("R1 blk_active", blk_active, 0);
        chk("R1 slot_cond", slot_cond, 4'hE);
        chk("R1 slot_pass", slot_pass, 1);
        chk("R1 err", err, 0);

        // R3/R7 table: one-slot block per condition
        for (int i = 0; i < 18; i++) begin
            nzcv = VEC[i][4:1];
            put(1, {8'hBF, VEC[i][8:5], 4'h8}, 0, 0);
            adv();
            put(0, 16'h0000, 0, 0);
            chk("R3 first slot cond", slot_cond, VEC[i][8:5]);
            chk("R7 cond eval", slot_pass, VEC[i][0]);
            put(1, 16'h0000, 0, 0);
            adv();
            put(0, 16'h0000, 0, 0);
            chk("R5 one-slot end", st_q, 8'h00);
        end

        // R6: 0xBF14 -> NE then EQ
        nzcv = 4'b0000;
        put(1, 16'hBF14, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R6 state", st_q, 8'h14);
        chk("R6 slot1 NE", slot_cond, 4'h1);
        chk("R6 slot1 pass", slot_pass, 1);
        put(1, 16'h0000, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R6 slot2 EQ", slot_cond, 4'h0);
        chk("R6 slot2 skip", slot_pass, 0);
        put(1, 16'h0000, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R6 end", st_q, 8'h00);

        // R4/R5: base EQ, slots T,T,E,T -> mask 0101
        put(1, 16'hBF05, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R4 s1", st_q, 8'h05);
        put(1, 16'h0000, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R4 s2 then", st_q, 8'h0A);
        put(1, 16'h0000, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R4 s3 else", st_q, 8'h14);
        chk("R4 s3 cond", slot_cond, 4'h1);
        put(1, 16'h0000, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R4 s4 then", st_q, 8'h08);
        put(1, 16'h0000, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R5 four-slot end", st_q, 8'h00);

        // R2: zero low nibble is not a prefix; R8: idle instruction
        put(1, 16'hBF00, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R2 non-prefix", st_q, 8'h00);
        put(1, 16'h1234, 0, 0); adv(); put(0, 16'h0000, 0, 0);
        chk("R8 idle hold", st_q, 8'h00);

        // R9: restore while idle, then restore colliding with retire
        st_wr = 1; st_wdata = 8'h14; adv(); st_wr = 0; #1;
        chk("R9 restore", st_q, 8'h14);
        chk("R9 restored cond", slot_cond, 4'h1);
        st_wr = 1; st_wdata = 8'h0A; put(1, 16'h0000, 0, 0); adv();
        st_wr = 0; put(0, 16'h0000, 0, 0);
        chk("R9 restore beats retire", st_q, 8'h0A);
        st_wr = 1; st_wdata = 8'h00; adv(); st_wr = 0; #1;

        // R10: nested prefix
        put(1, 16'hBF08, 0, 0); adv();
        put(1, 16'hBF18, 0, 0);
        chk("R10 nest err", err, 4'b0001);
        adv(); put(0, 16'h0000, 0, 0);
        chk("R10 nest advances", st_q, 8'h00);

        // R11: AL with else slot, and legal AL
        put(1, 16'hBFEC, 0, 0);
        chk("R11 al-else err", err, 4'b0010);
        adv(); put(0, 16'h0000, 0, 0);
        chk("R11 not loaded", st_q, 8'h00);
        put(1, 16'hBFE4, 0, 0);
        chk("R11 legal al err", err, 4'b0000);
        adv(); put(0, 16'h0000, 0, 0);
        chk("R11 legal al load", st_q, 8'hE4);

        // R12/R13 inside the block, then idle
        put(1, 16'h0000, 1, 0);
        chk("R12 branch in", err, 4'b0100);
        adv();
        put(1, 16'h0000, 0, 1);
        chk("R13 flag write", err, 4'b1000);
        put(1, 16'h0000, 1, 1);
        chk("R12 R13 both", err, 4'b1100);
        adv(); put(0, 16'h0000, 0, 0);
        chk("R5 al block end", st_q, 8'h00);
        put(1, 16'h0000, 1, 1);
        chk("R12 R13 idle quiet", err, 4'b0000);
        adv(); put(0, 16'h0000, 0, 0);

        summary();
    end
endmodule